// File: doc/BRIEF.md
# Reference-to-demodulation parameter converter

This block takes the latest estimate of an external reference and turns it into two words for a demodulation oscillator. The estimate is a phase (a timestamp in timer ticks) and a period (ticks per reference cycle). The two words are a 32-bit frequency word and a 32-bit starting phase word. One result is produced for every processing batch. A batch is started by a single-cycle tick. An estimate offered with that tick replaces the stored one. Without an estimate, the stored one is used again.

Both words come from a rounded division by the reference period. The phase word also depends on a batch index that wraps, so each batch starts the oscillator at the phase the reference has reached at that batch. Two serial rounding dividers run side by side and produce one quotient bit per clock. While they work, the block reports busy and ignores further ticks. When the stored period is zero, no division is started and both words are forced to all-ones.

Top module: `ref_demod_conv`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, freq_word_o and phase_word_o are all zero. The batch index, the stored phase and the stored period also reset to zero.
- R2: A tick is accepted when busy_o is low. If est_valid_i is high in that cycle, est_phase_i and est_period_i become the stored phase and period. If it is low, the previously stored pair is used.
- R3: For a nonzero stored period P, freq_word_o = floor((2^(32+TICKS_LOG2) + floor(P/2)) / P) mod 2^32.
- R4: For a nonzero P, let D be the signed 32-bit value of (index * 2^(TICKS_LOG2+BATCH_LOG2) - stored phase) mod 2^32. Then phase_word_o = floor((D * 2^32 + floor(P/2)) / P) mod 2^32, using floor division, so negative D rounds correctly as well.
- R5: If the stored period is zero, both words become 32'hFFFF_FFFF. done_o is high in the cycle after the first clock edge that follows acceptance.
- R6: For a nonzero period, done_o is a one-cycle pulse that rises 67 clock edges after the accepting edge. busy_o is high from the accepting edge until the edge that raises done_o. The output words change only at that edge and hold until the next done.
- R7: A tick that arrives while busy_o is high is ignored, together with any estimate offered with it.
- R8: The batch index starts at 0 and advances by one at every done. After 2^(32-TICKS_LOG2-BATCH_LOG2)-1 it wraps to 0. The stored phase is reduced by 2^32 at the wrap, which leaves its 32-bit value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| batch_tick_i | input | 1 | Start of a processing batch |
| est_valid_i | input | 1 | Qualifies the estimate offered with the tick |
| est_phase_i | input | 32 | Reference phase timestamp, ticks |
| est_period_i | input | 32 | Reference period, ticks |
| busy_o | output | 1 | Computation in progress; ticks ignored |
| done_o | output | 1 | One-cycle result strobe |
| freq_word_o | output | 32 | Oscillator frequency word |
| phase_word_o | output | 32 | Oscillator initial phase word |

## Verification
The bench drives phases above the scaled batch index, so the phase numerator goes negative. A divider that truncates toward zero instead of flooring is then off by one in the phase word. Periods of 1, 2, 7 and all-ones check the rounding half-step and the truncation of the oversized quotient to 32 bits. A period of zero must produce all-ones in one cycle; a design that divides anyway would hang or return garbage. Ticks are injected while busy, and more than one full index wrap is run. A design that accepts a busy tick, or wraps the index one batch early or late, therefore shows a shifted phase word.

// File: rtl/ref_demod_pkg.sv
`timescale 1ns/1ps
package ref_demod_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NUM_W  = 2 * WORD_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN
  } conv_st_e;
endpackage

// File: rtl/ref_demod_rdiv.sv
`timescale 1ns/1ps
// Floor-rounded signed / unsigned divide, one quotient bit per clock.
module ref_demod_rdiv #(
  parameter int unsigned NW = 64,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,   // two's complement numerator
  input  logic [DW-1:0] den_i,   // unsigned, nonzero
  output logic          fin_o,
  output logic [DW-1:0] quo_o
);
  localparam int unsigned MW = NW + 1;
  localparam int unsigned CW = $clog2(MW + 1);
  localparam logic [MW-1:0] ONE_M = 1;

  logic [MW-1:0] num_x, den_x, m_sum, mag;
  logic          neg;
  logic [MW-1:0] quo_q;
  logic [DW-1:0] rem_q, den_q, rem_n;
  logic [DW:0]   r_sh;
  logic          ge;
  logic [CW-1:0] cnt_q;
  logic          run_q, neg_q, fin_q;

  always_comb begin
    num_x = {num_i[NW-1], num_i};
    den_x = {{(MW-DW){1'b0}}, den_i};
    m_sum = num_x + (den_x >> 1);
    neg   = m_sum[MW-1];
    // negative: magnitude of ceil(-m/den) via (-m + den - 1) = ~m + den
    mag   = neg ? (~m_sum + den_x) : m_sum;
  end

  always_comb begin
    r_sh  = {rem_q, quo_q[MW-1]};
    ge    = r_sh >= {1'b0, den_q};
    rem_n = ge ? DW'(r_sh - {1'b0, den_q}) : r_sh[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      neg_q <= 1'b0;
      fin_q <= 1'b0;
    end else if (start_i) begin
      quo_q <= mag;
      rem_q <= '0;
      den_q <= den_i;
      cnt_q <= CW'(MW);
      run_q <= 1'b1;
      neg_q <= neg;
      fin_q <= 1'b0;
    end else if (run_q) begin
      quo_q <= {quo_q[MW-2:0], ge};
      rem_q <= rem_n;
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign fin_o = fin_q;
  assign quo_o = DW'(neg_q ? (~quo_q + ONE_M) : quo_q);

  // R5
  start_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> den_i != '0);
  // R7
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);
  // R6
  fin_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);
endmodule

// File: rtl/ref_demod_batch.sv
`timescale 1ns/1ps
// Wrapping batch index.
module ref_demod_batch #(
  parameter int unsigned IW = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] IDX_MAX = '1;

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (adv_i)  idx_q <= (idx_q == IDX_MAX) ? '0 : idx_q + IW'(1);
  end

  assign idx_o = idx_q;

  // R8
  idx_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && idx_q == IDX_MAX) |=> idx_q == '0);
  // R8
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && idx_q != IDX_MAX) |=> idx_q == $past(idx_q) + IW'(1));
  // R8
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
endmodule

// File: rtl/ref_demod_conv.sv
`timescale 1ns/1ps
module ref_demod_conv
  import ref_demod_pkg::*;
#(
  parameter int unsigned TICKS_LOG2 = 8,
  parameter int unsigned BATCH_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              batch_tick_i,
  input  logic              est_valid_i,
  input  logic [WORD_W-1:0] est_phase_i,
  input  logic [WORD_W-1:0] est_period_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] freq_word_o,
  output logic [WORD_W-1:0] phase_word_o
);
  localparam int unsigned SHIFT_W = TICKS_LOG2 + BATCH_LOG2;
  localparam int unsigned IDX_W   = WORD_W - SHIFT_W;
  localparam logic [NUM_W-1:0] FREQ_NUM = {{(NUM_W-1){1'b0}}, 1'b1} << (WORD_W + TICKS_LOG2);

  conv_st_e          st_q;
  logic [WORD_W-1:0] ref_ph_q, ref_per_q, freq_q, phase_q;
  logic              done_q;
  logic [IDX_W-1:0]  idx;
  logic              per_zero, div_start, div_fin, fin_f, fin_p, adv;
  logic [WORD_W-1:0] quo_f, quo_p, phase_diff;
  logic [NUM_W-1:0]  phase_num;

  always_comb begin
    per_zero   = (ref_per_q == '0);
    // 2^32 taken off the stored phase at a wrap is invisible mod 2^32
    phase_diff = {idx, {SHIFT_W{1'b0}}} - ref_ph_q;
    phase_num  = {phase_diff, {WORD_W{1'b0}}};
    div_start  = (st_q == ST_LOAD) && !per_zero;
    div_fin    = fin_f & fin_p;
    adv        = ((st_q == ST_LOAD) && per_zero) || ((st_q == ST_RUN) && div_fin);
  end

  ref_demod_rdiv #(.NW(NUM_W), .DW(WORD_W)) u_div_freq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (FREQ_NUM),
    .den_i   (ref_per_q),
    .fin_o   (fin_f),
    .quo_o   (quo_f)
  );

  ref_demod_rdiv #(.NW(NUM_W), .DW(WORD_W)) u_div_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (phase_num),
    .den_i   (ref_per_q),
    .fin_o   (fin_p),
    .quo_o   (quo_p)
  );

  ref_demod_batch #(.IW(IDX_W)) u_batch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .idx_o  (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ref_ph_q  <= '0;
      ref_per_q <= '0;
      freq_q    <= '0;
      phase_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (batch_tick_i) begin
          st_q <= ST_LOAD;
          if (est_valid_i) begin
            ref_ph_q  <= est_phase_i;
            ref_per_q <= est_period_i;
          end
        end
        ST_LOAD: if (per_zero) begin
          freq_q  <= '1;
          phase_q <= '1;
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end else begin
          st_q <= ST_RUN;
        end
        ST_RUN: if (div_fin) begin
          freq_q  <= quo_f;
          phase_q <= quo_p;
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign freq_word_o  = freq_q;
  assign phase_word_o = phase_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  run_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !div_fin) |=> busy_o);
  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && batch_tick_i) |=> ($stable(ref_ph_q) && $stable(ref_per_q)));
  // R5
  zero_words_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && per_zero) |=> (done_o && freq_word_o == '1 && phase_word_o == '1));
  // R6
  words_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> ($stable(freq_word_o) || done_o));
  // R3
  fin_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_f == fin_p);
endmodule

// File: tb/ref_demod_conv_bench.sv
`timescale 1ns/1ps
module ref_demod_conv_bench;
  localparam int unsigned T_L2  = 12;
  localparam int unsigned B_L2  = 16;
  localparam int unsigned SH    = T_L2 + B_L2;
  localparam int unsigned IMAX  = (1 << (32 - SH)) - 1;
  localparam int          LAT   = 67;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        batch_tick_i = 1'b0;
  logic        est_valid_i = 1'b0;
  logic [31:0] est_phase_i = '0;
  logic [31:0] est_period_i = '0;
  logic        busy_o, done_o;
  logic [31:0] freq_word_o, phase_word_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_tag = "R1";

  ref_demod_conv #(.TICKS_LOG2(T_L2), .BATCH_LOG2(B_L2)) u_ref_demod_conv (
    .clk_i(clk_i), .rst_ni(rst_ni), .batch_tick_i(batch_tick_i),
    .est_valid_i(est_valid_i), .est_phase_i(est_phase_i), .est_period_i(est_period_i),
    .busy_o(busy_o), .done_o(done_o), .freq_word_o(freq_word_o), .phase_word_o(phase_word_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) act=%h exp=%h at cycle %0d", tag, cur_tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] floor_div(input longint n, input logic [31:0] per);
    longint b = longint'({32'h0, per});
    longint m = n + (b >>> 1);
    longint q = m / b;
    if ((m % b) != 0 && m < 0) q = q - 1;
    return q[31:0];
  endfunction

  // behavioural model
  bit          m_busy, m_done;
  int          m_left;
  int unsigned m_idx;
  logic [31:0] m_ph, m_per, e_f, e_p;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_left = 0; m_idx = 0;
      m_ph = '0; m_per = '0; e_f = '0; e_p = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          logic [31:0] d;
          m_busy = 0;
          m_done = 1;
          if (m_per == 0) begin
            e_f = '1; e_p = '1;
          end else begin
            d   = (32'(m_idx) << SH) - m_ph;
            e_f = floor_div(64'sd1 <<< (32 + T_L2), m_per);
            e_p = floor_div(longint'(signed'(d)) <<< 32, m_per);
          end
          m_idx = (m_idx == IMAX) ? 0 : m_idx + 1;
        end
      end else if (batch_tick_i) begin
        if (est_valid_i) begin
          m_ph = est_phase_i; m_per = est_period_i;
        end
        m_busy = 1;
        m_left = (m_per == 0) ? 1 : LAT;
      end
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(busy_o == 0 && done_o == 0, "R1 ctl", {30'b0, busy_o, done_o}, 32'h0);
      chk(freq_word_o == 0, "R1 freq", freq_word_o, 32'h0);
      chk(phase_word_o == 0, "R1 phase", phase_word_o, 32'h0);
    end else begin
      chk(busy_o == m_busy, "R6 busy", {31'b0, busy_o}, {31'b0, m_busy});
      chk(done_o == m_done, "R6 done", {31'b0, done_o}, {31'b0, m_done});
      chk(freq_word_o == e_f, (m_per == 0) ? "R5 freq" : "R3 freq", freq_word_o, e_f);
      chk(phase_word_o == e_p, (m_per == 0) ? "R5 phase" : "R4 phase", phase_word_o, e_p);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_batch(input bit v, input logic [31:0] ph, input logic [31:0] per);
    @(negedge clk_i);
    batch_tick_i = 1'b1; est_valid_i = v; est_phase_i = ph; est_period_i = per;
    @(negedge clk_i);
    batch_tick_i = 1'b0; est_valid_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    cur_tag = "R5 never loaded";
    run_batch(1'b0, 32'h0, 32'h0);

    cur_tag = "R2 R3 R4 load";
    run_batch(1'b1, 32'd1000, 32'd3000);
    cur_tag = "R2 reuse";
    run_batch(1'b0, 32'hDEAD_BEEF, 32'd5);
    run_batch(1'b0, 32'h0, 32'd0);

    cur_tag = "R4 negative numerator";
    run_batch(1'b1, 32'h9000_0000, 32'd7);
    cur_tag = "R3 R4 half rounding";
    run_batch(1'b1, 32'd5, 32'd2);
    cur_tag = "R3 unit period";
    run_batch(1'b1, 32'd0, 32'd1);
    cur_tag = "R3 max period";
    run_batch(1'b1, 32'h1234_5678, 32'hFFFF_FFFF);

    cur_tag = "R7 busy tick";
    @(negedge clk_i);
    batch_tick_i = 1'b1; est_valid_i = 1'b1; est_phase_i = 32'd100; est_period_i = 32'd5000;
    @(negedge clk_i);
    batch_tick_i = 1'b0; est_valid_i = 1'b0;
    repeat (10) @(negedge clk_i);
    batch_tick_i = 1'b1; est_valid_i = 1'b1; est_phase_i = 32'd7; est_period_i = 32'd9;
    @(negedge clk_i);
    batch_tick_i = 1'b0; est_valid_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
    run_batch(1'b0, 32'd7, 32'd9);

    cur_tag = "R8 wrap";
    for (int i = 0; i < 22; i++)
      run_batch((i % 3) == 0, 32'(i * 123457), 32'(1000 + i * 37));

    cur_tag = "R5 zero period";
    run_batch(1'b1, 32'd77, 32'd0);
    cur_tag = "R2 R5 reuse zero";
    run_batch(1'b0, 32'd1, 32'd1);

    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule